// File: doc/BRIEF.md
# Unaligned Word Access Splitter

This block connects a 16-bit processor core to a memory bus that can only move naturally aligned 16-bit words. The core presents one request at a time: a byte address, a size (byte or word), a read/write flag and 16-bit write data. The block turns that request into one or two aligned bus cycles, routes each byte onto the correct lane and rebuilds the read result. It then returns the result with a single-cycle completion pulse.

Memory is byte addressed and little-endian. A word occupies two consecutive bytes, and its address is the lower one. The byte at that address carries word bits 7:0. A word may start at an odd address. In that case it straddles two aligned words and takes two bus cycles. A mode input selects a 20-bit or a 24-bit physical address space. Address bits above the active width are forced to zero, and the second half of a split access wraps to address zero inside the active space.

The core issues a request with a one-cycle `req_valid` while the block is idle, and waits for `rsp_done` before it issues the next one. The mode input is held steady while a request is in flight.

Top module: `split_access_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no request, `mem_valid` and `rsp_done` are low.
- R2: With `mode_wide` = 0, every bus address has bits 23:20 forced to zero. With `mode_wide` = 1, all 24 address bits pass through.
- R3: A word request at an even address makes exactly one bus cycle to that address with `mem_be` = 2'b11. On a write, `mem_wdata` equals the request data. On a read, `rsp_rdata` equals `mem_rdata`.
- R4: A byte request makes one bus cycle to the aligned word that contains the byte. An even address enables the lower lane (`mem_be` = 2'b01, data bits 7:0). An odd address enables the upper lane (`mem_be` = 2'b10, data bits 15:8). On a write, request bits 7:0 go onto the enabled lane and the disabled lane carries zero. On a read, the enabled lane is returned in `rsp_rdata[7:0]` with bits 15:8 zero.
- R5: A word request at an odd address A makes two bus cycles, in order. The first goes to A-1 with `mem_be` = 2'b10. The second goes to A+1 with `mem_be` = 2'b01.
- R6: On a split write, the first cycle drives request bits 7:0 on the upper lane and the second cycle drives request bits 15:8 on the lower lane. The disabled lane is zero in both cycles.
- R7: On a split read, `rsp_rdata[7:0]` is the upper lane of the first cycle and `rsp_rdata[15:8]` is the lower lane of the second cycle.
- R8: Address, lane enables, write flag and write data of a bus cycle stay unchanged from the cycle `mem_valid` rises until the clock edge at which `mem_ready` is sampled high.
- R9: `rsp_done` is high for exactly one clock, in the cycle right after the final bus cycle's handshake edge. `mem_valid` is low in that cycle.
- R10: When the second cycle of a split access would pass the top of the active address space, its address wraps to zero.
- R11: Every bus address is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide | input | 1 | 1 selects the 24-bit address space, 0 the 20-bit one |
| req_valid | input | 1 | One-cycle request strobe, taken while idle |
| req_addr | input | 24 | Byte address of the request |
| req_word | input | 1 | 1 for a word access, 0 for a byte access |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 16 | Write data, byte requests use bits 7:0 |
| rsp_rdata | output | 16 | Read result, valid while rsp_done is high |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Bus cycle in progress |
| mem_addr | output | 24 | Aligned byte address of the bus word |
| mem_be | output | 2 | Lane enables, bit 0 lower lane, bit 1 upper lane |
| mem_write | output | 1 | Bus cycle is a write |
| mem_wdata | output | 16 | Bus write data |
| mem_rdata | input | 16 | Bus read data |
| mem_ready | input | 1 | Bus cycle completes on the edge where this is high |

## Verification
The hardest situation to reach is a split word whose second half crosses the top of the active address space. It needs an odd address at the last byte of the space, and the correct mode must be selected. The bench targets it directly in both modes: the last byte of the 20-bit space with the narrow mode, and the last byte of the 24-bit space with the wide mode. The bus model returns read bytes that depend on the address, so a wrong second address shows up in the reassembled result. The hold rule is exercised with a bus model that delays ready by several cycles during a split access. The model compares each cycle's signals at the handshake against what it saw when the cycle began.

// File: rtl/sau_pkg.sv
package sau_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } sau_state_e;

  localparam int LANES   = 2;
  localparam int LANE_LO = 0;
  localparam int LANE_HI = 1;

  typedef logic [LANES-1:0] lane_en_t;

  localparam lane_en_t EN_LO   = 2'b01;
  localparam lane_en_t EN_HI   = 2'b10;
  localparam lane_en_t EN_BOTH = 2'b11;

endpackage

// File: rtl/sau_rst_sync.sv
module sau_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/sau_addr_limit.sv
module sau_addr_limit #(
  parameter int ADDR_W   = 24,
  parameter int NARROW_W = 20
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              mode_wide_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] mask_o
);

  localparam logic [ADDR_W-1:0] WIDE_MASK = '1;

  logic [ADDR_W-1:0] narrow_mask;

  generate
    if (NARROW_W >= ADDR_W) begin : g_no_narrow
      assign narrow_mask = WIDE_MASK;
    end else begin : g_narrow
      assign narrow_mask = {{(ADDR_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    end
  endgenerate

  always_comb begin
    mask_o = mode_wide_i ? WIDE_MASK : narrow_mask;
    addr_o = addr_i & mask_o;
  end

endmodule

// File: rtl/sau_lane_plan.sv
module sau_lane_plan
  import sau_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              second_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output lane_en_t          lane_en_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              split_o
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] base_addr;
  logic [ADDR_W-1:0] next_addr;
  logic              odd;
  logic [LANE_W-1:0] low_byte;
  logic [LANE_W-1:0] high_byte;
  logic [LANE_W-1:0] src [LANES];

  always_comb begin
    odd       = addr_i[0];
    base_addr = {addr_i[ADDR_W-1:1], 1'b0};
    next_addr = (base_addr + STEP) & mask_i;
    split_o   = word_i & odd;
    low_byte  = wdata_i[LANE_W-1:0];
    high_byte = wdata_i[DATA_W-1:LANE_W];
  end

  always_comb begin
    bus_addr_o   = base_addr;
    lane_en_o    = EN_LO;
    src[LANE_LO] = '0;
    src[LANE_HI] = '0;
    if (split_o) begin
      if (second_i) begin
        bus_addr_o   = next_addr;
        lane_en_o    = EN_LO;
        src[LANE_LO] = high_byte;
      end else begin
        lane_en_o    = EN_HI;
        src[LANE_HI] = low_byte;
      end
    end else if (word_i) begin
      lane_en_o    = EN_BOTH;
      src[LANE_LO] = low_byte;
      src[LANE_HI] = high_byte;
    end else if (odd) begin
      lane_en_o    = EN_HI;
      src[LANE_HI] = low_byte;
    end else begin
      lane_en_o    = EN_LO;
      src[LANE_LO] = low_byte;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign bus_wdata_o[g*LANE_W +: LANE_W] = lane_en_o[g] ? src[g] : '0;
    end
  endgenerate

endmodule

// File: rtl/sau_seq.sv
module sau_seq
  import sau_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid_i,
  input  logic split_i,
  input  logic ready_i,
  output logic accept_o,
  output logic hs_first_split_o,
  output logic hs_final_o,
  output logic bus_valid_o,
  output logic second_o
);

  sau_state_e state_q;
  sau_state_e state_d;

  always_comb begin
    state_d          = state_q;
    accept_o         = 1'b0;
    hs_first_split_o = 1'b0;
    hs_final_o       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid_i) begin
          accept_o = 1'b1;
          state_d  = ST_FIRST;
        end
      end
      ST_FIRST: begin
        if (ready_i) begin
          if (split_i) begin
            hs_first_split_o = 1'b1;
            state_d          = ST_SECOND;
          end else begin
            hs_final_o = 1'b1;
            state_d    = ST_IDLE;
          end
        end
      end
      ST_SECOND: begin
        if (ready_i) begin
          hs_final_o = 1'b1;
          state_d    = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign bus_valid_o = (state_q != ST_IDLE);
  assign second_o    = (state_q == ST_SECOND);

endmodule

// File: rtl/sau_read_merge.sv
module sau_read_merge
  import sau_pkg::*;
#(
  parameter int LANE_W = 8,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_first_split_i,
  input  logic              hs_final_i,
  input  logic              split_i,
  input  logic              word_i,
  input  logic              odd_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o
);

  logic [LANE_W-1:0] keep_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  logic [DATA_W-1:0] result_d;
  logic [LANE_W-1:0] lane_lo;
  logic [LANE_W-1:0] lane_hi;

  always_comb begin
    lane_lo = bus_rdata_i[LANE_W-1:0];
    lane_hi = bus_rdata_i[DATA_W-1:LANE_W];
    if (split_i) begin
      result_d = {lane_lo, keep_q};
    end else if (word_i) begin
      result_d = bus_rdata_i;
    end else if (odd_i) begin
      result_d = {{LANE_W{1'b0}}, lane_hi};
    end else begin
      result_d = {{LANE_W{1'b0}}, lane_lo};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q <= '0;
    end else if (hs_first_split_i) begin
      keep_q <= lane_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (hs_final_i) begin
      rdata_q <= result_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else begin
      done_q <= hs_final_i;
    end
  end

  assign rdata_o = rdata_q;
  assign done_o  = done_q;

endmodule

// File: rtl/split_access_unit.sv
module split_access_unit
  import sau_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int NARROW_W = 20,
  parameter int LANE_W   = 8,
  localparam int DATA_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wide,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_be,
  output logic              mem_write,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);

  logic              rst_n_s;
  logic [ADDR_W-1:0] lim_addr;
  logic [ADDR_W-1:0] lim_mask;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] mask_q;
  logic              word_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;
  logic              hs_first_split;
  logic              hs_final;
  logic              bus_valid;
  logic              second;
  logic              split;
  logic [ADDR_W-1:0] bus_addr;
  lane_en_t          lane_en;
  logic [DATA_W-1:0] bus_wdata;

  sau_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  sau_addr_limit #(
    .ADDR_W   (ADDR_W),
    .NARROW_W (NARROW_W)
  ) u_addr_limit (
    .addr_i      (req_addr),
    .mode_wide_i (mode_wide),
    .addr_o      (lim_addr),
    .mask_o      (lim_mask)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q  <= '0;
      mask_q  <= '0;
      word_q  <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= lim_addr;
      mask_q  <= lim_mask;
      word_q  <= req_word;
      write_q <= req_write;
      wdata_q <= req_wdata;
    end
  end

  sau_lane_plan #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W)
  ) u_lane_plan (
    .addr_i      (addr_q),
    .mask_i      (mask_q),
    .word_i      (word_q),
    .wdata_i     (wdata_q),
    .second_i    (second),
    .bus_addr_o  (bus_addr),
    .lane_en_o   (lane_en),
    .bus_wdata_o (bus_wdata),
    .split_o     (split)
  );

  sau_seq u_seq (
    .clk              (clk),
    .rst_n            (rst_n_s),
    .req_valid_i      (req_valid),
    .split_i          (split),
    .ready_i          (mem_ready),
    .accept_o         (accept),
    .hs_first_split_o (hs_first_split),
    .hs_final_o       (hs_final),
    .bus_valid_o      (bus_valid),
    .second_o         (second)
  );

  sau_read_merge #(
    .LANE_W (LANE_W)
  ) u_read_merge (
    .clk              (clk),
    .rst_n            (rst_n_s),
    .hs_first_split_i (hs_first_split),
    .hs_final_i       (hs_final),
    .split_i          (split),
    .word_i           (word_q),
    .odd_i            (addr_q[0]),
    .bus_rdata_i      (mem_rdata),
    .rdata_o          (rsp_rdata),
    .done_o           (rsp_done)
  );

  assign mem_valid = bus_valid;
  assign mem_addr  = bus_addr;
  assign mem_be    = lane_en;
  assign mem_write = bus_valid & write_q;
  assign mem_wdata = bus_wdata;

endmodule

// File: rtl/sau_checker.sv
module sau_checker #(
  parameter int ADDR_W   = 24,
  parameter int NARROW_W = 20,
  parameter int DATA_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_wide,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_be,
  input logic              mem_write,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready,
  input logic              rsp_done
);

  localparam int LW = DATA_W / 2;

  p_even_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !mem_addr[0]);

  p_lane_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_be != 2'b00));

  p_hold_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_be)
                                   && $stable(mem_write) && $stable(mem_wdata)));

  p_addr_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mode_wide) |-> ((mem_addr >> NARROW_W) == '0));

  p_idle_lo_lane_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && !mem_be[0]) |-> (mem_wdata[LW-1:0] == '0));

  p_idle_hi_lane_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && !mem_be[1]) |-> (mem_wdata[DATA_W-1:LW] == '0));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_done_after_hs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $past(mem_valid && mem_ready));

  p_bus_quiet_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !mem_valid);

endmodule

bind split_access_unit sau_checker #(
  .ADDR_W   (ADDR_W),
  .NARROW_W (NARROW_W),
  .DATA_W   (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_wide (mode_wide),
  .mem_valid (mem_valid),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_write (mem_write),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready),
  .rsp_done  (rsp_done)
);

// File: tb/split_access_unit_tb.sv
module split_access_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        mode_wide;
  logic        req_valid;
  logic [23:0] req_addr;
  logic        req_word;
  logic        req_write;
  logic [15:0] req_wdata;
  logic [15:0] rsp_rdata;
  logic        rsp_done;
  logic        mem_valid;
  logic [23:0] mem_addr;
  logic [1:0]  mem_be;
  logic        mem_write;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_ready;

  int checks;
  int fails;
  int cyc;
  int wait_cfg;
  int wcnt;
  int hold_err;
  int nlog;
  logic [23:0] lg_addr  [8];
  logic [1:0]  lg_be    [8];
  logic        lg_write [8];
  logic [15:0] lg_wdata [8];
  int          lg_cyc   [8];
  logic [23:0] snap_addr;
  logic [1:0]  snap_be;
  logic        snap_write;
  logic [15:0] snap_wdata;

  split_access_unit u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_wide (mode_wide),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_word  (req_word),
    .req_write (req_write),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata),
    .rsp_done  (rsp_done),
    .mem_valid (mem_valid),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_write (mem_write),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] byte_at(input logic [23:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h96;
  endfunction

  assign mem_rdata = {byte_at(mem_addr + 24'd1), byte_at(mem_addr)};

  // Bus model: ready after wait_cfg idle cycles, logs each completed cycle.
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0;
      wcnt      <= 0;
    end else if (mem_ready) begin
      mem_ready <= 1'b0;
      wcnt      <= 0;
    end else if (mem_valid) begin
      if (wcnt == 0) begin
        snap_addr  = mem_addr;
        snap_be    = mem_be;
        snap_write = mem_write;
        snap_wdata = mem_wdata;
      end
      if (wcnt >= wait_cfg) begin
        mem_ready <= 1'b1;
        if (snap_addr != mem_addr || snap_be != mem_be ||
            snap_write != mem_write || snap_wdata != mem_wdata)
          hold_err = hold_err + 1;
        if (nlog < 8) begin
          lg_addr[nlog]  = mem_addr;
          lg_be[nlog]    = mem_be;
          lg_write[nlog] = mem_write;
          lg_wdata[nlog] = mem_wdata;
          lg_cyc[nlog]   = cyc;
        end
        nlog = nlog + 1;
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic ok, input logic [31:0] act,
                     input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One core request, with bus cycles and result compared to a model.
  task automatic access(input string req, input logic wide, input logic [23:0] a,
                        input logic w, input logic wr, input logic [15:0] wd);
    logic [23:0] m, am, base, nxt;
    logic [23:0] e_addr [2];
    logic [1:0]  e_be   [2];
    logic [15:0] e_wd   [2];
    logic [15:0] e_rd;
    int          n_exp, start, guard, done_cyc;
    m    = wide ? 24'hFF_FFFF : 24'h0F_FFFF;
    am   = a & m;
    base = {am[23:1], 1'b0};
    nxt  = (base + 24'd2) & m;
    if (w && am[0]) begin
      n_exp = 2;
      e_addr[0] = base; e_be[0] = 2'b10; e_wd[0] = {wd[7:0], 8'h00};
      e_addr[1] = nxt;  e_be[1] = 2'b01; e_wd[1] = {8'h00, wd[15:8]};
      e_rd = {byte_at(nxt), byte_at(base + 24'd1)};
    end else if (w) begin
      n_exp = 1;
      e_addr[0] = base; e_be[0] = 2'b11; e_wd[0] = wd;
      e_rd = {byte_at(base + 24'd1), byte_at(base)};
    end else begin
      n_exp = 1;
      e_addr[0] = base;
      e_be[0] = am[0] ? 2'b10 : 2'b01;
      e_wd[0] = am[0] ? {wd[7:0], 8'h00} : {8'h00, wd[7:0]};
      e_rd = {8'h00, byte_at(am)};
    end
    e_addr[1] = (n_exp == 2) ? e_addr[1] : 24'h0;
    start = nlog;
    @(negedge clk);
    mode_wide = wide;
    req_valid = 1'b1;
    req_addr  = a;
    req_word  = w;
    req_write = wr;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    guard = 0;
    while (!rsp_done && guard < 200) begin
      @(negedge clk);
      guard = guard + 1;
    end
    done_cyc = cyc;
    chk({req, " done seen"}, rsp_done, 32'(rsp_done), 32'd1);
    chk({req, " bus cycle count"}, (nlog - start) == n_exp, 32'(nlog - start), 32'(n_exp));
    for (int i = 0; i < n_exp && (start + i) < 8; i++) begin
      chk({req, " bus address"}, lg_addr[start+i] == e_addr[i], 32'(lg_addr[start+i]), 32'(e_addr[i]));
      chk("R11 even bus address", lg_addr[start+i][0] == 1'b0, 32'(lg_addr[start+i][0]), 32'd0);
      chk({req, " lane enables"}, lg_be[start+i] == e_be[i], 32'(lg_be[start+i]), 32'(e_be[i]));
      chk({req, " write flag"}, lg_write[start+i] == wr, 32'(lg_write[start+i]), 32'(wr));
      if (wr)
        chk({req, " write data"}, lg_wdata[start+i] == e_wd[i], 32'(lg_wdata[start+i]), 32'(e_wd[i]));
    end
    if (!wr)
      chk({req, " read result"}, rsp_rdata == e_rd, 32'(rsp_rdata), 32'(e_rd));
    if ((nlog - start) == n_exp && (start + n_exp) <= 8)
      chk("R9 done one cycle after final handshake", done_cyc == lg_cyc[start+n_exp-1] + 1,
          32'(done_cyc), 32'(lg_cyc[start+n_exp-1] + 1));
    chk("R9 bus idle at done", !mem_valid, 32'(mem_valid), 32'd0);
    @(negedge clk);
    chk("R9 done lasts one cycle", !rsp_done, 32'(rsp_done), 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 mem_valid in reset", !mem_valid, 32'(mem_valid), 32'd0);
    chk("R1 rsp_done in reset", !rsp_done, 32'(rsp_done), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 mem_valid after reset", !mem_valid, 32'(mem_valid), 32'd0);
    chk("R1 rsp_done after reset", !rsp_done, 32'(rsp_done), 32'd0);
  endtask

  task automatic t_aligned_word();
    access("R3 aligned write", 1'b1, 24'h00_1234, 1'b1, 1'b1, 16'hBEEF);
    access("R3 aligned read", 1'b1, 24'h00_0100, 1'b1, 1'b0, 16'h0000);
  endtask

  task automatic t_bytes();
    access("R4 even byte write", 1'b1, 24'h00_0010, 1'b0, 1'b1, 16'h77AA);
    access("R4 odd byte write", 1'b1, 24'h00_0011, 1'b0, 1'b1, 16'h5566);
    access("R4 odd byte read", 1'b1, 24'h12_3457, 1'b0, 1'b0, 16'hFFFF);
    access("R4 even byte read", 1'b1, 24'h12_3456, 1'b0, 1'b0, 16'hFFFF);
  endtask

  task automatic t_split_write();
    access("R5 R6 split write", 1'b1, 24'h00_0203, 1'b1, 1'b1, 16'hC3D2);
  endtask

  task automatic t_split_read();
    access("R5 R7 split read", 1'b1, 24'h0A_BC0F, 1'b1, 1'b0, 16'h0000);
  endtask

  task automatic t_mode_limit();
    access("R2 narrow mode masks", 1'b0, 24'hF3_4566, 1'b1, 1'b0, 16'h0000);
    access("R2 wide mode keeps", 1'b1, 24'hF3_4566, 1'b1, 1'b0, 16'h0000);
    access("R2 narrow byte write", 1'b0, 24'hA0_0021, 1'b0, 1'b1, 16'h0042);
  endtask

  task automatic t_wrap();
    access("R10 narrow wrap write", 1'b0, 24'h0F_FFFF, 1'b1, 1'b1, 16'h1357);
    access("R10 narrow wrap read", 1'b0, 24'h7F_FFFF, 1'b1, 1'b0, 16'h0000);
    access("R10 wide wrap read", 1'b1, 24'hFF_FFFF, 1'b1, 1'b0, 16'h0000);
  endtask

  task automatic t_wait_hold();
    hold_err = 0;
    wait_cfg = 3;
    access("R8 split read with waits", 1'b1, 24'h00_4441, 1'b1, 1'b0, 16'h0000);
    access("R8 split write with waits", 1'b0, 24'h00_8885, 1'b1, 1'b1, 16'hA1B2);
    chk("R8 bus held until ready", hold_err == 0, 32'(hold_err), 32'd0);
    wait_cfg = 0;
  endtask

  initial begin
    checks    = 0;
    fails     = 0;
    cyc       = 0;
    wait_cfg  = 0;
    hold_err  = 0;
    nlog      = 0;
    rst_n     = 1'b0;
    mode_wide = 1'b1;
    req_valid = 1'b0;
    req_addr  = '0;
    req_word  = 1'b0;
    req_write = 1'b0;
    req_wdata = '0;
    fork
      begin
        t_reset();
        t_aligned_word();
        t_bytes();
        t_split_write();
        t_split_read();
        t_mode_limit();
        t_wrap();
        t_wait_hold();
      end
      begin
        repeat (100000) @(posedge clk);
        checks = checks + 1;
        fails  = fails + 1;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule